// File: doc/BRIEF.md
# SAR Converter Sequencer

This block is the digital front end for an external 10-bit successive-approximation converter. Everything runs on the 16 MHz base clock. A clock-enable divider produces the converter clock, with a programmable ratio. The sequencer issues a sample request, counts converter-clock cycles and captures the converter's 10-bit result bus at a fixed point after the request. It then presents the captured code in two forms: a valid window one converter cycle wide, and a single-cycle pulse in the base-clock domain that travels with the data.

While the enable bit is set and the converter reset bit is clear, sampling is continuous. A new period starts as soon as the previous one ends, and the period length in converter cycles is programmable. The analog source select and the pin select are forwarded to the analog multiplexer. They are latched at the start of each period, so they never change in the middle of a conversion. Divider and period values outside their legal ranges are clamped rather than rejected.

Top module: `sar_seq`

## Requirements
- R1: The converter clock period is D base-clock cycles, where D is the divider field clamped to the range 10..80. The clock is high for the first floor(D/2) base cycles of each converter cycle. It is low while the sequencer is idle.
- R2: The sample request is high for the whole first converter cycle of every period. The first period begins on the base-clock edge where enable is seen high with the reset bit low.
- R3: The converter-domain valid is high for exactly one converter cycle: the 15th converter cycle counted from the start of a period, where the period's first cycle is number 1.
- R4: The base-domain valid is a one-cycle pulse in the first base-clock cycle of that 15th converter cycle.
- R5: The result output takes the value on the converter bus at the edge that starts the 15th cycle. It holds that value until the next capture, including while the block is disabled.
- R6: A period lasts P converter cycles, where P is the cycles-per-sample field with values below 14 raised to 14. Periods follow each other with no gap. When P is 14, the valid window of one conversion coincides with the sample request of the next.
- R7: The source-select output (00 temperature voltage, 01 external voltage) and the pin-select output (00..11 for external inputs 0..3) are copied from their inputs at the start of each period. They hold until the next period starts.
- R8: When the converter reset bit is 1, sampling stops and the result, both valids, the sample request and both select outputs are cleared on the next edge. This holds whatever the enable bit is.
- R9: Clearing enable stops sampling on the next edge. A conversion cut off this way produces no valid, and the previous result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Converter enable |
| cfg_rst | input | 1 | Converter reset, active high |
| cfg_div | input | 8 | Base-clock divider for the converter clock |
| cfg_cps | input | 5 | Converter cycles per sample period |
| cfg_src | input | 2 | Source select request |
| cfg_pin | input | 2 | External pin select request |
| conv_bits | input | 10 | Result bus from the converter |
| conv_clk | output | 1 | Converter clock |
| conv_sample | output | 1 | Sample request |
| mux_src | output | 2 | Latched source select |
| mux_pin | output | 2 | Latched pin select |
| conv_valid | output | 1 | Valid window, one converter cycle |
| res_valid | output | 1 | Valid pulse, one base cycle |
| res_data | output | 10 | Captured result |

## Verification
The assertions assume that the configuration inputs are synchronous to the base clock. They also assume that the converter bus is stable across the capture edge, which is why the converter stub in the bench changes its code only on the falling edge. The hold check for the result assumes that no capture and no converter reset happen in the cycle being checked. The bench changes divider and period values only while the sequencer is disabled, so its behavioural model can treat D and P as constant for a whole run. Source and pin selects are also changed during a run, to exercise the per-period latching.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Converter cycles from sample start to the end of a conversion.
  localparam int unsigned CONV_CYCLES = 14;

  typedef struct packed {
    logic [1:0] src;
    logic [1:0] pin;
  } mux_sel_t;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_MIN = 10,
  parameter int unsigned DIV_MAX = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             running,
  input  logic [DIV_W-1:0] div_raw,
  output logic             tick,
  output logic             conv_clk
);
  localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] div_lim;
  logic             clk_q, clk_d;
  logic             wrap;

  always_comb begin
    if (div_raw < LO)      div_lim = LO;
    else if (div_raw > HI) div_lim = HI;
    else                   div_lim = div_raw;
  end

  assign wrap = (cnt_q == div_q - DIV_W'(1));
  assign tick = running && wrap;

  always_comb begin
    cnt_d = cnt_q;
    div_d = div_q;
    if (!go) begin
      cnt_d = '0;
    end else if (!running || wrap) begin
      cnt_d = '0;
      div_d = div_lim;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
    clk_d = go && (cnt_d < (div_d >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= LO;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      clk_q <= clk_d;
    end
  end

  assign conv_clk = clk_q;

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q >= LO) && (div_q <= HI)); // R1
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned CPS_W     = 5,
  parameter int unsigned CPS_MIN   = 14,
  parameter int unsigned DONE_CYC  = CONV_CYCLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_rst,
  input  logic              tick,
  input  logic [CPS_W-1:0]  cps_raw,
  input  mux_sel_t          sel_in,
  input  logic [DATA_W-1:0] conv_bits,
  output logic              running,
  output logic              sample,
  output mux_sel_t          sel_out,
  output logic              conv_valid,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam logic [CPS_W-1:0] P_LO  = CPS_W'(CPS_MIN);
  localparam logic [CPS_W-1:0] C_END = CPS_W'(DONE_CYC - 1);

  logic              run_q, run_d;
  logic [CPS_W-1:0]  cyc_q, cyc_d;
  logic [CPS_W-1:0]  cps_q, cps_d;
  logic [CPS_W-1:0]  cps_lim;
  mux_sel_t          sel_q, sel_d;
  logic              cv_q, cv_d;
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              last, capt;

  assign cps_lim = (cps_raw < P_LO) ? P_LO : cps_raw;
  assign last    = (cyc_q == cps_q - CPS_W'(1));
  assign capt    = tick && (cyc_q == C_END);

  always_comb begin
    run_d = run_q;
    cyc_d = cyc_q;
    cps_d = cps_q;
    sel_d = sel_q;
    cv_d  = cv_q;
    rv_d  = 1'b0;
    res_d = res_q;
    if (cfg_rst) begin
      run_d = 1'b0;
      cyc_d = '0;
      sel_d = '0;
      cv_d  = 1'b0;
      res_d = '0;
    end else if (!cfg_en) begin
      run_d = 1'b0;
      cyc_d = '0;
      cv_d  = 1'b0;
    end else if (!run_q) begin
      run_d = 1'b1;
      cyc_d = '0;
      cps_d = cps_lim;
      sel_d = sel_in;
      cv_d  = 1'b0;
    end else if (tick) begin
      cv_d = 1'b0;
      if (capt) begin
        res_d = conv_bits;
        cv_d  = 1'b1;
        rv_d  = 1'b1;
      end
      if (last) begin
        cyc_d = '0;
        cps_d = cps_lim;
        sel_d = sel_in;
      end else begin
        cyc_d = cyc_q + CPS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cyc_q <= '0;
      cps_q <= P_LO;
      sel_q <= '0;
      cv_q  <= 1'b0;
      rv_q  <= 1'b0;
      res_q <= '0;
    end else begin
      run_q <= run_d;
      cyc_q <= cyc_d;
      cps_q <= cps_d;
      sel_q <= sel_d;
      cv_q  <= cv_d;
      rv_q  <= rv_d;
      res_q <= res_d;
    end
  end

  assign running    = run_q;
  assign sample     = run_q && (cyc_q == '0);
  assign sel_out    = sel_q;
  assign conv_valid = cv_q;
  assign res_valid  = rv_q;
  assign res_data   = res_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R4
  AST_PULSE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> conv_valid); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !$past(cfg_rst)) |-> $stable(res_q)); // R5
  AST_OVERLAP_ONLY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_valid) |-> (!sample || (cps_q == P_LO))); // R6
  AST_CPS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    cps_q >= P_LO); // R6
  AST_CFG_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst |=> (!run_q && (res_q == '0) && !cv_q)); // R8
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!run_q && !rv_q)); // R9
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned CPS_W   = 5,
  parameter int unsigned DIV_MIN = 10,
  parameter int unsigned DIV_MAX = 80,
  parameter int unsigned CPS_MIN = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [CPS_W-1:0]  cfg_cps,
  input  logic [1:0]        cfg_src,
  input  logic [1:0]        cfg_pin,
  input  logic [DATA_W-1:0] conv_bits,
  output logic              conv_clk,
  output logic              conv_sample,
  output logic [1:0]        mux_src,
  output logic [1:0]        mux_pin,
  output logic              conv_valid,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       go;
  logic       running;
  logic       tick;
  mux_sel_t   sel_in, sel_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign go         = cfg_en && !cfg_rst;
  assign sel_in.src = cfg_src;
  assign sel_in.pin = cfg_pin;

  sar_clk_div #(
    .DIV_W   (DIV_W),
    .DIV_MIN (DIV_MIN),
    .DIV_MAX (DIV_MAX)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .go       (go),
    .running  (running),
    .div_raw  (cfg_div),
    .tick     (tick),
    .conv_clk (conv_clk)
  );

  sar_conv_ctrl #(
    .DATA_W   (DATA_W),
    .CPS_W    (CPS_W),
    .CPS_MIN  (CPS_MIN),
    .DONE_CYC (CONV_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cfg_en     (cfg_en),
    .cfg_rst    (cfg_rst),
    .tick       (tick),
    .cps_raw    (cfg_cps),
    .sel_in     (sel_in),
    .conv_bits  (conv_bits),
    .running    (running),
    .sample     (conv_sample),
    .sel_out    (sel_out),
    .conv_valid (conv_valid),
    .res_valid  (res_valid),
    .res_data   (res_data)
  );

  assign mux_src = sel_out.src;
  assign mux_pin = sel_out.pin;
endmodule

// File: tb/sar_seq_tb_top.sv
`timescale 1ns/1ps
module sar_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_rst = 1'b0;
  logic [7:0] cfg_div = 8'd10;
  logic [4:0] cfg_cps = 5'd14;
  logic [1:0] cfg_src = 2'b00;
  logic [1:0] cfg_pin = 2'b00;
  logic [9:0] conv_bits = 10'h155;
  logic       conv_clk, conv_sample, conv_valid, res_valid;
  logic [1:0] mux_src, mux_pin;
  logic [9:0] res_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sar_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rst(cfg_rst),
    .cfg_div(cfg_div), .cfg_cps(cfg_cps), .cfg_src(cfg_src), .cfg_pin(cfg_pin),
    .conv_bits(conv_bits), .conv_clk(conv_clk), .conv_sample(conv_sample),
    .mux_src(mux_src), .mux_pin(mux_pin), .conv_valid(conv_valid),
    .res_valid(res_valid), .res_data(res_data)
  );

  // Converter stub: a new pseudo-random code every base cycle, changed on the falling edge.
  always @(negedge clk)
    conv_bits <= {conv_bits[8:0], conv_bits[9] ^ conv_bits[6]};

  // Behavioural reference model: elapsed base cycles since the run started.
  bit m_run = 1'b0;
  int m_t = 0, m_d = 10, m_p = 14;
  int m_res = 0, m_src = 0, m_pin = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 1'b0; m_res = 0; m_src = 0; m_pin = 0; m_t = 0;
    end else if (cfg_rst) begin
      m_run = 1'b0; m_res = 0; m_src = 0; m_pin = 0;
    end else if (!cfg_en) begin
      m_run = 1'b0;
    end else if (!m_run) begin
      m_run = 1'b1; m_t = 0;
      m_d = (cfg_div < 10) ? 10 : (cfg_div > 80) ? 80 : int'(cfg_div);
      m_p = (cfg_cps < 14) ? 14 : int'(cfg_cps);
      m_src = cfg_src; m_pin = cfg_pin;
    end else begin
      m_t++;
      if (m_t % m_d == 0) begin
        int ci;
        ci = m_t / m_d;
        if (ci >= 14 && (ci - 14) % m_p == 0) m_res = conv_bits;
        if (ci % m_p == 0) begin m_src = cfg_src; m_pin = cfg_pin; end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int ci, ph;
      bit hit;
      ci  = m_t / m_d;
      ph  = m_t % m_d;
      hit = m_run && ci >= 14 && ((ci - 14) % m_p == 0);
      chk("R1 conv_clk", conv_clk, int'(m_run && ph < m_d / 2));
      chk("R2 R6 conv_sample", conv_sample, int'(m_run && (ci % m_p == 0)));
      chk("R3 conv_valid", conv_valid, int'(hit));
      chk("R4 res_valid", res_valid, int'(hit && ph == 0));
      chk("R5 R8 R9 res_data", res_data, m_res);
      chk("R7 mux_src", mux_src, m_src);
      chk("R7 mux_pin", mux_pin, m_pin);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_case(input int dv, input int cp, input int sr, input int pn, input int len);
    cfg_div = 8'(dv); cfg_cps = 5'(cp); cfg_src = 2'(sr); cfg_pin = 2'(pn);
    cfg_en = 1'b1;
    wait_cyc(len);
    cfg_en = 1'b0;
    wait_cyc(20);
  endtask

  initial begin
    wait_cyc(5);
    // Reset state (R8 clear values) before release
    chk("R8 reset res_data", res_data, 0);
    chk("R2 reset conv_sample", conv_sample, 0);
    rst_n = 1'b1;
    wait_cyc(6);
    // R1 R2 R3 R4 R5 R6: minimum divider, minimum period, back-to-back
    run_case(10, 14, 1, 0, 470);
    // R1 low clamp, R6 longer period
    run_case(3, 20, 0, 3, 600);
    // R1 high clamp, R6 low clamp
    run_case(200, 5, 1, 1, 2340);
    // R1 odd divider, R6 maximum period
    run_case(13, 31, 1, 2, 1100);
    // R7: selects changed during a run, taken at the next period start
    cfg_div = 8'd16; cfg_cps = 5'd14; cfg_src = 2'b01; cfg_pin = 2'b00;
    cfg_en = 1'b1;
    wait_cyc(300);
    cfg_src = 2'b00; cfg_pin = 2'b11;
    wait_cyc(400);
    cfg_en = 1'b0;
    wait_cyc(30);
    // R9: disable before the capture point, result held
    run_case(10, 14, 1, 1, 100);
    // R8: converter reset while enabled, then restart
    cfg_div = 8'd10; cfg_cps = 5'd15; cfg_en = 1'b1;
    wait_cyc(200);
    cfg_rst = 1'b1;
    wait_cyc(20);
    chk("R8 cleared res_data", res_data, 0);
    cfg_rst = 1'b0;
    wait_cyc(400);
    cfg_en = 1'b0;
    wait_cyc(20);
    // R1 zero divider clamps up
    run_case(0, 14, 0, 2, 400);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule